// File: doc/BRIEF.md
# Interrupt Context Bank Stack

This block gives a processor core a hardware store for its working context, so that interrupt entry and return need no memory traffic. When the core accepts an interrupt that is marked for banked handling, it presents a snapshot of its register file, together with the accepted interrupt's vector offset, on a wide parallel bus. The block writes that snapshot in a single clock cycle into the next free bank, so the save finishes well inside the window between the start of exception handling and the first fetch of the service routine.

The banks form a last-in first-out stack. A visible level counter names the next free bank. Saves fill the banks from bank 0 upward. A return request hands back the most recently stored snapshot and frees its bank. Misuse is flagged on single-cycle status pulses. A save into a full stack raises the overflow pulse, a restore from an empty stack raises the underflow pulse, and a restore that arrives in the same cycle as a save raises the conflict pulse.

Top module: `irq_ctx_bank_stack`

## Requirements
- R1: After a synchronous active-high reset, bank_level is 0, ctx_out is all zeros, and save_done, restore_done, overflow, underflow and conflict_err are low.
- R2: When save_req and bank_en are both high and bank_level is below 15, the full ctx_in value is stored in the bank numbered bank_level. After the next rising edge, bank_level has increased by one and save_done is high for exactly that one cycle.
- R3: When restore_req is high, save_req is low and bank_level is not 0, the rising edge decrements bank_level by one and loads ctx_out with the contents of the bank at the new level. restore_done is high for that one cycle.
- R4: Restores return snapshots in the reverse order of the saves that stored them, and no snapshot is returned twice.
- R5: A save_req with bank_en low changes neither bank_level nor any bank's contents, and it raises no pulse.
- R6: A save requested with bank_en high while bank_level equals 15 stores nothing and leaves bank_level at 15. overflow is high for the following cycle.
- R7: A restore requested (with save_req low) while bank_level is 0 leaves bank_level at 0 and ctx_out unchanged. underflow is high for the following cycle and restore_done stays low.
- R8: When save_req and restore_req are high in the same cycle, the save is handled as if it were alone (R2, R5, R6) and the restore is dropped. conflict_err is high for the following cycle.
- R9: The context is 20 words of 32 bits. Word k sits at bits [32k+31:32k]. Words 0 to 14 are the general registers, word 15 is the global base register, words 16 and 17 are the high and low halves of the multiply-accumulate register, word 18 is the return register and word 19 is the vector offset. Every one of the 640 bits is stored and returned unaltered.
- R10: Every status output (save_done, restore_done, overflow, underflow, conflict_err) is a registered pulse that lasts one cycle per request. It is low in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| save_req | input | 1 | Interrupt accepted; requests a context save |
| bank_en | input | 1 | Banking enabled for the accepted interrupt |
| restore_req | input | 1 | Return from interrupt; requests a context restore |
| ctx_in | input | 640 | Context snapshot to save (20 words of 32 bits) |
| ctx_out | output | 640 | Restored context snapshot |
| bank_level | output | 4 | Number of the next free bank (0 to 15) |
| save_done | output | 1 | Pulse: a save was stored |
| restore_done | output | 1 | Pulse: ctx_out holds a freshly restored snapshot |
| overflow | output | 1 | Pulse: save refused, all banks full |
| underflow | output | 1 | Pulse: restore refused, no bank in use |
| conflict_err | output | 1 | Pulse: restore dropped because a save arrived in the same cycle |

## Verification
Directed sequences first store three snapshots whose words all differ and then pop them. A storage or ordering fault then shows up as a wrong word at a known position, not as a near match. The stack is driven to both walls: the bench fills all fifteen banks and then saves again, and it also restores from empty. These runs separate a counter that wraps or saturates wrongly from one that stops correctly. Saves with banking disabled and saves paired with restores in the same cycle show whether the enable gate and the save-over-restore priority work. Several hundred mixed random requests with random 640-bit data, checked against a stack model in the bench, then cover interleavings the directed cases miss.

// File: rtl/ictx_pkg.sv
package ictx_pkg;

   // Non-general words that follow the general registers in a context image
   localparam int unsigned EXTRA_WORDS = 5;

   // Word positions relative to the end of the general register block
   localparam int unsigned OFS_GBR  = 0;
   localparam int unsigned OFS_MACH = 1;
   localparam int unsigned OFS_MACL = 2;
   localparam int unsigned OFS_RET  = 3;
   localparam int unsigned OFS_VEC  = 4;

   // Outcome of one request cycle as decided by the controller
   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_PUSH    = 3'd1,
      OP_POP     = 3'd2,
      OP_PUSH_XF = 3'd3,
      OP_POP_XF  = 3'd4
   } stack_op_e;

   typedef struct packed {
      logic save_done;
      logic restore_done;
      logic overflow;
      logic underflow;
      logic conflict;
   } stack_flags_t;

endpackage

// File: rtl/ictx_ctrl.sv
module ictx_ctrl
   import ictx_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 15,
   parameter int unsigned LEVEL_W   = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               save_req,
   input  logic               bank_en,
   input  logic               restore_req,
   output logic [LEVEL_W-1:0] level,
   output logic               wr_en,
   output logic [LEVEL_W-1:0] wr_idx,
   output logic               rd_en,
   output logic [LEVEL_W-1:0] rd_idx,
   output stack_flags_t       flags
);

   localparam logic [LEVEL_W-1:0] LEVEL_FULL = LEVEL_W'(NUM_BANKS);
   localparam logic [LEVEL_W-1:0] LEVEL_ONE  = LEVEL_W'(1);

   logic              full, empty;
   logic              push_try, pop_try;
   stack_op_e         op;
   logic [LEVEL_W-1:0] level_d;
   stack_flags_t      flags_d;

   assign full  = (level == LEVEL_FULL);
   assign empty = (level == '0);

   // A save request outranks a restore in the same cycle
   assign push_try = save_req & bank_en;
   assign pop_try  = restore_req & ~save_req;

   always_comb begin
      op = OP_IDLE;
      if (push_try)
         op = full ? OP_PUSH_XF : OP_PUSH;
      else if (pop_try)
         op = empty ? OP_POP_XF : OP_POP;
   end

   assign wr_en  = (op == OP_PUSH);
   assign wr_idx = level;
   assign rd_en  = (op == OP_POP);
   assign rd_idx = level - LEVEL_ONE;

   always_comb begin
      level_d = level;
      unique case (op)
         OP_PUSH: level_d = level + LEVEL_ONE;
         OP_POP:  level_d = level - LEVEL_ONE;
         default: level_d = level;
      endcase
   end

   always_comb begin
      flags_d              = '0;
      flags_d.save_done    = (op == OP_PUSH);
      flags_d.restore_done = (op == OP_POP);
      flags_d.overflow     = (op == OP_PUSH_XF);
      flags_d.underflow    = (op == OP_POP_XF);
      flags_d.conflict     = save_req & restore_req;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= '0;
         flags <= '0;
      end else begin
         level <= level_d;
         flags <= flags_d;
      end
   end

endmodule

// File: rtl/ictx_bank_array.sv
module ictx_bank_array #(
   parameter int unsigned NUM_BANKS      = 15,
   parameter int unsigned LEVEL_W        = 4,
   parameter int unsigned CTX_W          = 640,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [LEVEL_W-1:0] wr_idx,
   input  logic [CTX_W-1:0]   wr_data,
   input  logic [LEVEL_W-1:0] rd_idx,
   output logic [CTX_W-1:0]   rd_data
);

   logic [CTX_W-1:0] slot_view [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
      logic             hit;
      logic [CTX_W-1:0] slot_q;

      assign hit = wr_en && (wr_idx == LEVEL_W'(b));

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)
               slot_q <= '0;
            else if (hit)
               slot_q <= wr_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit)
               slot_q <= wr_data;
         end
      end

      assign slot_view[b] = slot_q;
   end

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_idx == LEVEL_W'(b))
            rd_data = slot_view[b];
      end
   end

endmodule

// File: rtl/ictx_out_stage.sv
module ictx_out_stage #(
   parameter int unsigned CTX_W = 640
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CTX_W-1:0] din,
   output logic [CTX_W-1:0] dout
);

   always_ff @(posedge clk) begin
      if (rst)
         dout <= '0;
      else if (load)
         dout <= din;
   end

endmodule

// File: rtl/irq_ctx_bank_stack.sv
module irq_ctx_bank_stack
   import ictx_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned NUM_GPR        = 15,
   parameter int unsigned NUM_BANKS      = 15,
   parameter int unsigned LEVEL_W        = 4,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic                                       clk,
   input  logic                                       rst,
   input  logic                                       save_req,
   input  logic                                       bank_en,
   input  logic                                       restore_req,
   input  logic [(NUM_GPR+EXTRA_WORDS)*DATA_W-1:0]    ctx_in,
   output logic [(NUM_GPR+EXTRA_WORDS)*DATA_W-1:0]    ctx_out,
   output logic [LEVEL_W-1:0]                         bank_level,
   output logic                                       save_done,
   output logic                                       restore_done,
   output logic                                       overflow,
   output logic                                       underflow,
   output logic                                       conflict_err
);

   localparam int unsigned CTX_WORDS = NUM_GPR + EXTRA_WORDS;
   localparam int unsigned CTX_W     = CTX_WORDS * DATA_W;

   if (DATA_W == 0 || NUM_GPR == 0 || NUM_BANKS == 0) begin : g_bad_size
      $error("irq_ctx_bank_stack: sizes must be nonzero");
   end
   if (NUM_BANKS >= (1 << LEVEL_W)) begin : g_bad_level
      $error("irq_ctx_bank_stack: LEVEL_W too narrow for NUM_BANKS");
   end

   logic               wr_en, rd_en;
   logic [LEVEL_W-1:0] wr_idx, rd_idx;
   logic [CTX_W-1:0]   rd_data;
   stack_flags_t       flags;

   ictx_ctrl #(
      .NUM_BANKS (NUM_BANKS),
      .LEVEL_W   (LEVEL_W)
   ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .save_req    (save_req),
      .bank_en     (bank_en),
      .restore_req (restore_req),
      .level       (bank_level),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .rd_en       (rd_en),
      .rd_idx      (rd_idx),
      .flags       (flags)
   );

   ictx_bank_array #(
      .NUM_BANKS      (NUM_BANKS),
      .LEVEL_W        (LEVEL_W),
      .CTX_W          (CTX_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_banks (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (ctx_in),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   ictx_out_stage #(
      .CTX_W (CTX_W)
   ) u_out (
      .clk  (clk),
      .rst  (rst),
      .load (rd_en),
      .din  (rd_data),
      .dout (ctx_out)
   );

   assign save_done    = flags.save_done;
   assign restore_done = flags.restore_done;
   assign overflow     = flags.overflow;
   assign underflow    = flags.underflow;
   assign conflict_err = flags.conflict;

endmodule

// File: rtl/ictx_checker.sv
module ictx_checker #(
   parameter int unsigned NUM_BANKS = 15,
   parameter int unsigned LEVEL_W   = 4,
   parameter int unsigned CTX_W     = 640
) (
   input logic               clk,
   input logic               rst,
   input logic               save_req,
   input logic               bank_en,
   input logic               restore_req,
   input logic [CTX_W-1:0]   ctx_out,
   input logic [LEVEL_W-1:0] bank_level,
   input logic               save_done,
   input logic               restore_done,
   input logic               overflow,
   input logic               underflow,
   input logic               conflict_err
);

   localparam logic [LEVEL_W-1:0] TOP = LEVEL_W'(NUM_BANKS);

   // R2: accepted save with room advances the level and pulses save_done
   a_r2_save_advances: assert property (@(posedge clk) disable iff (rst)
      (save_req && bank_en && bank_level < TOP)
      |=> (save_done && bank_level == $past(bank_level) + LEVEL_W'(1)));

   // R3: restore from a non-empty stack steps the level down
   a_r3_restore_steps: assert property (@(posedge clk) disable iff (rst)
      (restore_req && !save_req && bank_level != '0)
      |=> (restore_done && bank_level == $past(bank_level) - LEVEL_W'(1)));

   // R5: disabled save leaves the level alone
   a_r5_disabled_save: assert property (@(posedge clk) disable iff (rst)
      (save_req && !bank_en)
      |=> ($stable(bank_level) && !save_done && !overflow));

   // R6: save into a full stack is refused
   a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
      (save_req && bank_en && bank_level == TOP)
      |=> (overflow && !save_done && bank_level == TOP));

   // R7: restore from empty is refused and output holds
   a_r7_underflow: assert property (@(posedge clk) disable iff (rst)
      (restore_req && !save_req && bank_level == '0)
      |=> (underflow && !restore_done && $stable(ctx_out) && bank_level == '0));

   // R8: simultaneous requests flag the dropped restore
   a_r8_conflict: assert property (@(posedge clk) disable iff (rst)
      (save_req && restore_req) |=> (conflict_err && !restore_done && !underflow));

   // R10: no request means no pulse on the next cycle
   a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
      (!save_req && !restore_req)
      |=> !(save_done || restore_done || overflow || underflow || conflict_err));

   // R10: only one of the restore outcomes at a time
   a_r10_restore_excl: assert property (@(posedge clk) disable iff (rst)
      $onehot0({restore_done, underflow}));

   // R6: level never exceeds bank count
   a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
      bank_level <= TOP);

endmodule

bind irq_ctx_bank_stack ictx_checker #(
   .NUM_BANKS (NUM_BANKS),
   .LEVEL_W   (LEVEL_W),
   .CTX_W     ((NUM_GPR + ictx_pkg::EXTRA_WORDS) * DATA_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .save_req     (save_req),
   .bank_en      (bank_en),
   .restore_req  (restore_req),
   .ctx_out      (ctx_out),
   .bank_level   (bank_level),
   .save_done    (save_done),
   .restore_done (restore_done),
   .overflow     (overflow),
   .underflow    (underflow),
   .conflict_err (conflict_err)
);

// File: tb/irq_ctx_bank_stack_test.sv
module irq_ctx_bank_stack_test;

   localparam int WORDS = 20;
   localparam int CW    = WORDS * 32;
   localparam int NB    = 15;

   logic          clk = 1'b0;
   logic          rst;
   logic          save_req, bank_en, restore_req;
   logic [CW-1:0] ctx_in, ctx_out;
   logic [3:0]    bank_level;
   logic          save_done, restore_done, overflow, underflow, conflict_err;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [CW-1:0] m_bank [NB];
   int            m_level;
   logic [CW-1:0] m_out;

   always #5 clk = ~clk;

   irq_ctx_bank_stack uut (
      .clk          (clk),
      .rst          (rst),
      .save_req     (save_req),
      .bank_en      (bank_en),
      .restore_req  (restore_req),
      .ctx_in       (ctx_in),
      .ctx_out      (ctx_out),
      .bank_level   (bank_level),
      .save_done    (save_done),
      .restore_done (restore_done),
      .overflow     (overflow),
      .underflow    (underflow),
      .conflict_err (conflict_err)
   );

   task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] rand_ctx();
      logic [CW-1:0] v;
      for (int k = 0; k < WORDS; k++) v[k*32 +: 32] = $urandom();
      return v;
   endfunction

   // Pattern with a distinct value in every word, tagged by snapshot number (R9)
   function automatic logic [CW-1:0] tagged_ctx(input int tag);
      logic [CW-1:0] v;
      for (int k = 0; k < WORDS; k++) v[k*32 +: 32] = {8'(tag), 8'(k), 16'hA5C3 ^ 16'(k * 257)};
      return v;
   endfunction

   // One request cycle: drive at negedge, let one rising edge pass, check outputs
   task automatic op(input bit s, input bit e, input bit r, input logic [CW-1:0] d, input string tag);
      bit x_sd, x_rd, x_ov, x_ud, x_cf;
      @(negedge clk);
      save_req = s; bank_en = e; restore_req = r; ctx_in = d;
      x_sd = 0; x_rd = 0; x_ov = 0; x_ud = 0; x_cf = s && r;
      if (s && e) begin
         if (m_level < NB) begin
            m_bank[m_level] = d; m_level++; x_sd = 1;
         end else x_ov = 1;
      end else if (r && !s) begin
         if (m_level > 0) begin
            m_level--; m_out = m_bank[m_level]; x_rd = 1;
         end else x_ud = 1;
      end
      @(posedge clk);
      #2;
      chk({tag, " R2/R3 level"}, CW'(bank_level), CW'(m_level));
      chk({tag, " R2 save_done"}, CW'(save_done), CW'(x_sd));
      chk({tag, " R3 restore_done"}, CW'(restore_done), CW'(x_rd));
      chk({tag, " R6 overflow"}, CW'(overflow), CW'(x_ov));
      chk({tag, " R7 underflow"}, CW'(underflow), CW'(x_ud));
      chk({tag, " R8 conflict_err"}, CW'(conflict_err), CW'(x_cf));
      chk({tag, " R4/R9 ctx_out"}, ctx_out, m_out);
   endtask

   task automatic idle_chk(input string tag);
      op(0, 0, 0, '0, {tag, " R10 idle"});
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'h5EED_0042);
      save_req = 0; bank_en = 0; restore_req = 0; ctx_in = '0;
      m_level = 0; m_out = '0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      chk("R1 level", CW'(bank_level), '0);
      chk("R1 ctx_out", ctx_out, '0);
      chk("R1 pulses", CW'({save_done, restore_done, overflow, underflow, conflict_err}), '0);

      // R2/R3/R4/R9: three distinct snapshots round trip in reverse order
      for (int i = 0; i < 3; i++) op(1, 1, 0, tagged_ctx(i + 1), "push");
      idle_chk("after push R10");
      for (int i = 0; i < 3; i++) op(0, 0, 1, '0, "pop R4");
      idle_chk("after pop R10");

      // R7: restore from empty, output holds last snapshot
      op(0, 0, 1, '0, "R7 empty");
      op(0, 1, 1, '0, "R7 empty again");

      // R5: disabled save changes nothing
      op(1, 1, 0, tagged_ctx(9), "R5 base");
      op(1, 0, 0, tagged_ctx(10), "R5 disabled");
      op(0, 0, 1, '0, "R5 pop returns base");

      // R6: fill all banks, then overflow twice
      for (int i = 0; i < NB; i++) op(1, 1, 0, tagged_ctx(20 + i), "R6 fill");
      op(1, 1, 0, tagged_ctx(99), "R6 full");
      op(1, 1, 0, tagged_ctx(98), "R6 full again");
      // R8: save and restore together while full, then with room
      op(1, 1, 1, tagged_ctx(97), "R8 full clash");
      op(0, 0, 1, '0, "R6 top intact");
      op(1, 1, 1, tagged_ctx(96), "R8 clash saves");
      op(1, 0, 1, tagged_ctx(95), "R8 clash disabled");
      for (int i = 0; i < NB + 1; i++) op(0, 0, 1, '0, "R4 drain");

      // Random mix (R2-R10)
      for (int i = 0; i < 600; i++) begin
         int sel;
         bit s, e, r;
         sel = $urandom_range(0, 99);
         s = (sel < 45);
         e = ($urandom_range(0, 9) != 0);
         r = (sel >= 40 && sel < 90);
         op(s, e, r, rand_ctx(), "random");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule